// File: doc/BRIEF.md
# Banked Data-Space Window Decoder

This block sits between an 8-bit CPU's data bus and the memories of its data space. A 64-byte window at data addresses 00h to 3Fh is shared by several backing pages: an extra RAM page and a nonvolatile data page. Software picks the page that answers by writing a bank-select byte at data address E8h. Accesses to the window are steered to the enabled page with the address reduced to a 6-bit offset. Accesses elsewhere go to the ordinary data space unchanged.

The select byte can only be written. A read at E8h returns a fixed value and never its contents. Bit-level set and clear operations aimed at it are ignored. The byte has no reset, so it holds an undefined value until software writes it. Interrupts and calls leave it untouched. Each page has its own enable bit. If software sets more than one enable bit, several pages are selected together. The decoder still drives every enabled chip select, raises a conflict flag and returns all-ones read data.

Page index 0 is the nonvolatile data page and page index 1 is the extra RAM page.

Top module: `bank_window_decoder`

## Requirements
- R1: A full-byte write (`cpu_wr`=1, `cpu_bitop`=0) at address E8h loads `cpu_wdata` into the select byte at that clock edge. The new value steers accesses from the next cycle.
- R2: An access at E8h asserts no page chip select and no `base_cs`. A read there returns FFh, whatever the select byte holds.
- R3: For addresses 00h..3Fh, `win_offset` equals address bits 5..0 and `base_cs` stays low. No page chip select is ever asserted outside that range.
- R4: `page_cs[0]` follows select bit 0 and `page_cs[1]` follows select bit 4 during a window read or write. Select bits 7..5 and 3..1 have no effect.
- R5: A window access with neither enable bit set asserts no chip select and reads 00h.
- R6: With both enable bits set, a window access raises `conflict` and asserts both page chip selects. A read then returns FFh.
- R7: A write at E8h with `cpu_bitop`=1 leaves the select byte unchanged.
- R8: For addresses 40h..FFh other than E8h, `base_cs` equals `cpu_rd|cpu_wr` and a read returns `base_rdata`. `conflict` is low for these accesses.
- R9: The select byte is not altered by `rst`. It keeps its last written value across a reset pulse.
- R10: A window read with exactly one page enabled returns that page's slice of `page_rdata`. Page k occupies bits 8k+7..8k. With no read strobe, `cpu_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (select byte is not affected) |
| cpu_addr | input | 8 | CPU data address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_bitop | input | 1 | Marks the write as a single-bit set/clear operation |
| cpu_wdata | input | 8 | Write data |
| base_rdata | input | 8 | Read data from the ordinary data space |
| page_rdata | input | 16 | Read data from the pages, page k in bits 8k+7..8k |
| base_cs | output | 1 | Select for the ordinary data space |
| page_cs | output | 2 | Per-page chip selects |
| win_offset | output | 6 | Offset of the access inside the window |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| conflict | output | 1 | More than one page enabled during a window access |

## Verification
The hardest situation to reach from the ports is a select byte with several enable bits set together with ignored bits in arbitrary states. Software would only produce it by misuse. The bench gets there by writing every one of the 256 select values in turn. After each write it probes the window edges, a mid-window address, the first address past the window, and E8h. The bit-operation and reset cases are reached by loading a known page, attempting the change, and then reading the window to see which page still answers.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = 6;
    localparam int PAGE_COUNT = 2;
    localparam int CNT_W      = $clog2(PAGE_COUNT + 1);

    localparam logic [ADDR_W-1:0] SEL_ADDR = 8'hE8;
    localparam logic [DATA_W-1:0] EMPTY_RD = 8'h00;
    localparam logic [DATA_W-1:0] CLASH_RD = 8'hFF;
    localparam logic [DATA_W-1:0] SEL_RD   = 8'hFF;

    typedef enum logic [1:0] {
        RGN_BASE   = 2'd0,
        RGN_WINDOW = 2'd1,
        RGN_SELECT = 2'd2
    } region_e;

    typedef struct packed {
        region_e          rgn;
        logic [OFF_W-1:0] off;
        logic             rd;
        logic             wr;
    } access_t;

    // Select-byte bit that enables page k.
    function automatic int page_bit(input int k);
        case (k)
            0:       return 0;   // nonvolatile data page
            1:       return 4;   // extra RAM page
            default: return 0;
        endcase
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return (a >> OFF_W) == '0;
    endfunction

endpackage

// File: rtl/bwd_addr_dec.sv
module bwd_addr_dec
    import bwd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output access_t           acc
);

    always_comb begin
        acc.rd  = rd;
        acc.wr  = wr;
        acc.off = addr[OFF_W-1:0];
        if (addr == SEL_ADDR)
            acc.rgn = RGN_SELECT;
        else if (in_window(addr))
            acc.rgn = RGN_WINDOW;
        else
            acc.rgn = RGN_BASE;
    end

endmodule

// File: rtl/bwd_sel_reg.sv
module bwd_sel_reg
    import bwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic              bitop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sel_q
);

    logic hit_wr;
    logic load;

    assign hit_wr = acc.wr && (acc.rgn == RGN_SELECT);
    assign load   = hit_wr && !bitop;

    // Deliberately without reset: contents are undefined until written.
    always_ff @(posedge clk) begin
        if (load)
            sel_q <= wdata;
    end

    a_r1_full_write_loads: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.rgn == RGN_SELECT && !bitop) |=> sel_q == $past(wdata));

    a_r7_bitop_ignored: assert property (@(posedge clk) disable iff (rst)
        (hit_wr && bitop) |=> $stable(sel_q));

    a_r1_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        !hit_wr |=> $stable(sel_q));

endmodule

// File: rtl/bwd_page_steer.sv
module bwd_page_steer
    import bwd_pkg::*;
#(
    parameter int N_PAGES = PAGE_COUNT
)(
    input  logic                      clk,
    input  logic                      rst,
    input  access_t                   acc,
    input  logic [DATA_W-1:0]         sel_q,
    input  logic [DATA_W-1:0]         base_rdata,
    input  logic [N_PAGES*DATA_W-1:0] page_rdata,
    output logic                      base_cs,
    output logic [N_PAGES-1:0]        page_cs,
    output logic [DATA_W-1:0]         rdata,
    output logic                      conflict
);

    localparam int NC_W = $clog2(N_PAGES + 1);

    logic [N_PAGES-1:0] en;
    logic               win_act;
    logic [NC_W-1:0]    n_en;
    logic [DATA_W-1:0]  page_or;

    assign win_act = (acc.rgn == RGN_WINDOW) && (acc.rd || acc.wr);

    for (genvar k = 0; k < N_PAGES; k++) begin : g_page
        assign en[k]      = sel_q[page_bit(k)];
        assign page_cs[k] = win_act && en[k];
    end

    always_comb begin
        n_en    = '0;
        page_or = '0;
        for (int k = 0; k < N_PAGES; k++) begin
            if (en[k]) begin
                n_en    = n_en + NC_W'(1);
                page_or = page_or | page_rdata[k*DATA_W +: DATA_W];
            end
        end
    end

    assign conflict = win_act && (n_en > NC_W'(1));
    assign base_cs  = (acc.rgn == RGN_BASE) && (acc.rd || acc.wr);

    always_comb begin
        rdata = EMPTY_RD;
        if (acc.rd) begin
            unique case (acc.rgn)
                RGN_SELECT: rdata = SEL_RD;
                RGN_BASE:   rdata = base_rdata;
                RGN_WINDOW: begin
                    if (n_en > NC_W'(1))
                        rdata = CLASH_RD;
                    else if (n_en == NC_W'(1))
                        rdata = page_or;
                    else
                        rdata = EMPTY_RD;
                end
                default:    rdata = EMPTY_RD;
            endcase
        end
    end

    a_r2_select_no_cs: assert property (@(posedge clk) disable iff (rst)
        (acc.rgn == RGN_SELECT) |-> (page_cs == '0) && !base_cs);

    a_r3_cs_only_in_window: assert property (@(posedge clk) disable iff (rst)
        (page_cs != '0) |-> (acc.rgn == RGN_WINDOW) && !base_cs);

    a_r6_clash_reads_ones: assert property (@(posedge clk) disable iff (rst)
        (conflict && acc.rd) |-> (rdata == CLASH_RD) && ($countones(page_cs) > 1));

    a_r8_base_exclusive: assert property (@(posedge clk) disable iff (rst)
        base_cs |-> (page_cs == '0) && !conflict);

    a_r5_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |-> rdata == EMPTY_RD);

endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
    import bwd_pkg::*;
#(
    parameter int N_PAGES = PAGE_COUNT
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    input  logic                      cpu_bitop,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic [DATA_W-1:0]         base_rdata,
    input  logic [N_PAGES*DATA_W-1:0] page_rdata,
    output logic                      base_cs,
    output logic [N_PAGES-1:0]        page_cs,
    output logic [OFF_W-1:0]          win_offset,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      conflict
);

    access_t           acc;
    logic [DATA_W-1:0] sel_q;

    bwd_addr_dec u_dec (
        .addr (cpu_addr),
        .rd   (cpu_rd),
        .wr   (cpu_wr),
        .acc  (acc)
    );

    bwd_sel_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .bitop (cpu_bitop),
        .wdata (cpu_wdata),
        .sel_q (sel_q)
    );

    bwd_page_steer #(.N_PAGES(N_PAGES)) u_steer (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .sel_q      (sel_q),
        .base_rdata (base_rdata),
        .page_rdata (page_rdata),
        .base_cs    (base_cs),
        .page_cs    (page_cs),
        .rdata      (cpu_rdata),
        .conflict   (conflict)
    );

    assign win_offset = acc.off;

    a_r3_offset_tracks_addr: assert property (@(posedge clk) disable iff (rst)
        in_window(cpu_addr) |-> win_offset == cpu_addr[OFF_W-1:0]);

endmodule

// File: tb/bank_window_decoder_test.sv
module bank_window_decoder_test;
    import bwd_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cpu_addr = 8'h80;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_bitop = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  base_rdata;
    logic [15:0] page_rdata;
    logic        base_cs;
    logic [1:0]  page_cs;
    logic [5:0]  win_offset;
    logic [7:0]  cpu_rdata;
    logic        conflict;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memories modelled as address-dependent patterns.
    assign base_rdata         = ~cpu_addr;
    assign page_rdata[7:0]    = cpu_addr ^ 8'h5A;
    assign page_rdata[15:8]   = cpu_addr ^ 8'hC3;

    bank_window_decoder uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_bitop(cpu_bitop), .cpu_wdata(cpu_wdata),
        .base_rdata(base_rdata), .page_rdata(page_rdata),
        .base_cs(base_cs), .page_cs(page_cs), .win_offset(win_offset),
        .cpu_rdata(cpu_rdata), .conflict(conflict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at addr %02h: actual %0h expected %0h", req, cpu_addr, act, exp);
        end
    endtask

    task automatic write_sel(input logic [7:0] v, input logic bop);
        @(negedge clk);
        cpu_addr = SEL_ADDR; cpu_wdata = v; cpu_wr = 1'b1; cpu_rd = 1'b0; cpu_bitop = bop;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_bitop = 1'b0; cpu_addr = 8'h80;
    endtask

    task automatic access(input logic [7:0] a, input logic r, input logic w);
        @(negedge clk);
        cpu_addr = a; cpu_rd = r; cpu_wr = w;
        #1;
    endtask

    // Full expectation for one access given the select byte s.
    task automatic expect_all(input logic [7:0] s, input logic [7:0] a, input logic r, input logic w);
        logic act, e0, e1, win, sel;
        logic [7:0] rd_exp;
        win = (a < 8'h40);
        sel = (a == 8'hE8);
        act = r | w;
        e0  = s[0];
        e1  = s[4];
        if (!r)                rd_exp = 8'h00;
        else if (sel)          rd_exp = 8'hFF;
        else if (!win)         rd_exp = ~a;
        else if (e0 && e1)     rd_exp = 8'hFF;
        else if (e0)           rd_exp = a ^ 8'h5A;
        else if (e1)           rd_exp = a ^ 8'hC3;
        else                   rd_exp = 8'h00;
        if (sel) begin
            chk("R2 select-address chip selects", {base_cs, page_cs}, 3'b000);
            chk("R2 select-address read value", cpu_rdata, rd_exp);
        end else if (win) begin
            chk("R3 window offset", win_offset, a[5:0]);
            chk("R3 base_cs low in window", base_cs, 1'b0);
            chk("R4 page selects", page_cs, {act & e1, act & e0});
            chk("R6 conflict flag", conflict, act & e0 & e1);
            if (e0 ^ e1) chk("R10 single-page read", cpu_rdata, rd_exp);
            else if (e0) chk("R6 clash read", cpu_rdata, rd_exp);
            else         chk("R5 empty window read", cpu_rdata, rd_exp);
        end else begin
            chk("R8 base_cs", base_cs, act);
            chk("R8 base read", cpu_rdata, rd_exp);
            chk("R3 no page cs outside", page_cs, 2'b00);
            chk("R8 conflict low outside", conflict, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // Select byte has no reset value: load it while reset is held.
        write_sel(8'h00, 1'b0);
        access(8'h10, 1'b0, 1'b0);
        chk("R5 reset state no chip select", {base_cs, page_cs, conflict}, 4'b0000);
        chk("R10 reset state idle read data", cpu_rdata, 8'h00);
        @(negedge clk); rst = 1'b0;

        // R1/R4/R5/R6/R10: every select value, probing edges and neighbours.
        for (int s = 0; s < 256; s++) begin
            write_sel(8'(s), 1'b0);
            access(8'h00, 1'b1, 1'b0); expect_all(8'(s), 8'h00, 1'b1, 1'b0);
            access(8'h3F, 1'b1, 1'b0); expect_all(8'(s), 8'h3F, 1'b1, 1'b0);
            access(8'h25, 1'b0, 1'b1); expect_all(8'(s), 8'h25, 1'b0, 1'b1);
            access(8'h40, 1'b1, 1'b0); expect_all(8'(s), 8'h40, 1'b1, 1'b0);
            access(8'hE8, 1'b1, 1'b0); expect_all(8'(s), 8'hE8, 1'b1, 1'b0);
        end

        // R1 takes effect on the very next cycle.
        write_sel(8'h10, 1'b0);
        access(8'h07, 1'b1, 1'b0);
        chk("R1 new value steers next access", page_cs, 2'b10);

        // R8/R3: full address sweep with the RAM page enabled, reads and writes.
        for (int a = 0; a < 256; a++) begin
            access(8'(a), 1'b1, 1'b0); expect_all(8'h10, 8'(a), 1'b1, 1'b0);
            access(8'(a), 1'b0, 1'b1); expect_all(8'h10, 8'(a), 1'b0, 1'b1);
        end
        access(8'h12, 1'b0, 1'b0);
        chk("R4 no strobe no chip select", page_cs, 2'b00);

        // R7: bit-operation write at the select address is ignored.
        write_sel(8'h01, 1'b1);
        access(8'h11, 1'b1, 1'b0);
        chk("R7 bitop write ignored, page", page_cs, 2'b10);
        chk("R7 bitop write ignored, data", cpu_rdata, 8'h11 ^ 8'hC3);

        // R9: reset pulse leaves the select byte alone.
        write_sel(8'h01, 1'b0);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        access(8'h2A, 1'b1, 1'b0);
        chk("R9 select survives reset, page", page_cs, 2'b01);
        chk("R9 select survives reset, data", cpu_rdata, 8'h2A ^ 8'h5A);

        access(8'h80, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule